// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block brings a single-rank SDR SDRAM out of power-up and keeps it refreshed afterwards. After a start pulse it raises the clock-enable line and holds NOP for a programmable settle time. It then precharges every bank and issues a fixed number of back-to-back auto-refresh commands. Finally it loads the mode register and, once the load-to-command delay has passed, raises `init_done`. Each gap between commands is measured in SDRAM clock cycles and set by a parameter.

From then on, a free-running interval counter raises `ref_req` once per refresh period. An external arbiter answers with `ref_grant` when the command bus is free. The block then places one auto-refresh command on the pins and drops the request. A request that has not been granted stays pending. Requests never stack beyond one, so a late grant simply costs that refresh's slack.

The command pins and the bank and address lines are registered. Each command is therefore a full clean cycle on the bus. Read and write traffic, row tracking and the low-power modes are handled elsewhere.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and in the idle state after it, `sd_cke` is 0, the device is deselected (`sd_cs_n` = 1), and `init_done` and `ref_req` are 0.
- R2: A `start` pulse in the idle state raises `sd_cke` on the next cycle, with a NOP driven. Once the sequence has begun, `sd_cke` stays 1, and further `start` pulses, during bring-up or after it, change no output.
- R3: Precharge-all (cs_n, ras_n, cas_n, we_n = 0,0,1,0) appears exactly SETTLE_CYC cycles after `sd_cke` rises, with address bit 10 high and bank 0. It is issued exactly once.
- R4: Exactly NUM_INIT_REF (default 8) auto-refresh commands (0,0,0,1) are issued during bring-up. The first comes T_RP (2) cycles after the precharge, and each later one comes T_RC (6) cycles after the one before.
- R5: The mode-register load (0,0,0,0) comes T_RC cycles after the last bring-up refresh. It carries address value 0x0220 (burst length 1, sequential, CAS latency 2, standard mode, single-location writes via bit 9) on bank 0, and is issued exactly once.
- R6: `init_done` rises T_MRD (2) cycles after the mode-register load and stays high from then on.
- R7: Every cycle with `sd_cke` high that carries no command drives NOP (0,1,1,1).
- R8: `ref_req` is never high before `init_done`. It rises REF_INTERVAL (default 0x2A5) cycles after `init_done` rises. Later requests follow at multiples of REF_INTERVAL from that point, whatever the grant timing.
- R9: A raised `ref_req` stays high until granted. An interval that expires while a request is already pending adds nothing, so a single grant clears it.
- R10: `ref_grant` with `ref_req` high gives exactly one auto-refresh command on the next cycle, and `ref_req` is low in that cycle. `ref_grant` with `ref_req` low gives no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begins the power-up sequence when idle |
| ref_grant | input | 1 | Arbiter grant for a pending refresh |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal traffic |
| ref_req | output | 1 | Refresh needed, held until granted |

## Verification
A `start` sampled at a clock edge shows up as `sd_cke` in the cycle after that edge. After that, every command lands a fixed number of cycles after the one before: SETTLE_CYC, then T_RP, then T_RC for each refresh and for the mode load, then T_MRD to `init_done`. `ref_req` follows at each multiple of REF_INTERVAL, and a granted refresh appears one cycle after the grant edge. A monitor in the bench samples the pins at each falling edge and records the cycle number of every command and flag transition. The scenario tasks compare those numbers with offsets computed from the parameters, counted from the cycle in which the bench drove the stimulus. The refresh scenario places its grants well away from interval boundaries, so no check depends on a grant and an expiry landing on the same edge.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_INH,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT_RP,
    ST_WAIT_RC,
    ST_WAIT_MRD,
    ST_READY
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t encode_cmd(cmd_e c);
    cmd_pins_t p;
    case (c)
      CMD_NOP: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
  parameter int INTERVAL = 677
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic grant,
  output logic req
);

  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          expire;

  always_comb begin
    expire = run && (cnt_q == '0);
    if (!run || expire) cnt_d = RELOAD;
    else                cnt_d = cnt_q - CW'(1);
    pend_d = pend_q;
    if (pend_q && grant) pend_d = 1'b0;
    if (expire)          pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign req = pend_q;

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int              ADDR_W   = 13,
  parameter int              BA_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(16'h0220)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_d,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int ALL_BANK_BIT = 10;

  cmd_pins_t         pins_d, pins_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [ADDR_W-1:0] pre_addr;

  generate
    for (genvar i = 0; i < ADDR_W; i++) begin : g_pre_addr
      assign pre_addr[i] = (i == ALL_BANK_BIT);
    end
  endgenerate

  always_comb begin
    pins_d = encode_cmd(cmd_d);
    case (cmd_d)
      CMD_PRE: addr_d = pre_addr;
      CMD_MRS: addr_d = MODE_VAL;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= encode_cmd(CMD_INH);
      addr_q <= '0;
    end else begin
      pins_q <= pins_d;
      addr_q <= addr_d;
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
  assign ba    = '0;
  assign addr  = addr_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int                ADDR_W       = 13,
  parameter int                BA_W         = 2,
  parameter int                SETTLE_CYC   = 10000,
  parameter int                T_RP         = 2,
  parameter int                T_RC         = 6,
  parameter int                T_MRD        = 2,
  parameter int                NUM_INIT_REF = 8,
  parameter int                REF_INTERVAL = 677,
  parameter logic [ADDR_W-1:0] MODE_VAL     = ADDR_W'(16'h0220)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ref_grant,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              ref_req
);

  localparam int MAX_A = (SETTLE_CYC > T_RC) ? SETTLE_CYC : T_RC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_T + 1);
  localparam int RC_W  = $clog2(NUM_INIT_REF + 1);

  state_e           state_q, state_d;
  cmd_e             cmd_d;
  logic             cke_q, cke_d;
  logic             done_q, done_d;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;
  logic             tmr_ld;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;

  always_comb begin
    state_d = state_q;
    cke_d   = cke_q;
    done_d  = done_q;
    rcnt_d  = rcnt_q;
    cmd_d   = cke_q ? CMD_NOP : CMD_INH;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETTLE;
        cke_d   = 1'b1;
        cmd_d   = CMD_NOP;
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tmr_zero) begin
        state_d = ST_WAIT_RP;
        cmd_d   = CMD_PRE;
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(T_RP - 1);
      end
      ST_WAIT_RP: if (tmr_zero) begin
        state_d = ST_WAIT_RC;
        cmd_d   = CMD_REF;
        rcnt_d  = RC_W'(1);
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(T_RC - 1);
      end
      ST_WAIT_RC: if (tmr_zero) begin
        tmr_ld = 1'b1;
        if (rcnt_q == RC_W'(NUM_INIT_REF)) begin
          state_d = ST_WAIT_MRD;
          cmd_d   = CMD_MRS;
          tmr_val = TMR_W'(T_MRD - 1);
        end else begin
          cmd_d   = CMD_REF;
          rcnt_d  = rcnt_q + RC_W'(1);
          tmr_val = TMR_W'(T_RC - 1);
        end
      end
      ST_WAIT_MRD: if (tmr_zero) begin
        state_d = ST_READY;
        done_d  = 1'b1;
      end
      ST_READY: if (ref_req && ref_grant) cmd_d = CMD_REF;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cke_q   <= cke_d;
      done_q  <= done_d;
      rcnt_q  <= rcnt_d;
    end
  end

  sdram_cmd_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_ref_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (done_q),
    .grant (ref_grant),
    .req   (ref_req)
  );

  sdram_cmd_drive #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .MODE_VAL (MODE_VAL)
  ) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_d (cmd_d),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .ba    (sd_ba),
    .addr  (sd_addr)
  );

  assign sd_cke    = cke_q;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int                ADDR_W   = 13,
  parameter int                BA_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(16'h0220)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_grant,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done,
  input logic              ref_req
);

  logic is_pre, is_ref, is_mrs;
  assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
  assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
  assign is_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> sd_cs_n);

  p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);

  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sd_addr[10] && sd_ba == '0));

  p_mode_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_addr == MODE_VAL && sd_ba == '0 && !init_done));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_req_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> init_done);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req);

  p_grant_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && ref_req && ref_grant) |=> is_ref);

  p_no_ref_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !ref_req) |=> !is_ref);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .MODE_VAL (MODE_VAL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_grant (ref_grant),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .init_done (init_done),
  .ref_req   (ref_req)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int SETTLE = 50;
  localparam int TRP    = 2;
  localparam int TRC    = 6;
  localparam int TMRD   = 2;
  localparam int NREF   = 8;
  localparam int IVL    = 40;

  logic              clk, rst_n, start, ref_grant;
  logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0]   sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic              init_done, ref_req;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .SETTLE_CYC(SETTLE), .T_RP(TRP),
    .T_RC(TRC), .T_MRD(TMRD), .NUM_INIT_REF(NREF), .REF_INTERVAL(IVL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_grant(ref_grant),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .init_done(init_done), .ref_req(ref_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  // monitor records
  int cke_at = -1, pre_at = -1, mrs_at = -1, done_at = -1;
  int n_pre = 0, n_mrs = 0, n_ref_init = 0, n_ref_ready = 0, n_bad = 0;
  int ready_ref_at = -1;
  int n_rise = 0, n_fall = 0;
  int ref_at  [0:15];
  int rise_at [0:7];
  logic pre_a10_ok = 1'b1, mrs_ok = 1'b1;
  logic p_cke = 1'b0, p_done = 1'b0, p_req = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_cke && !p_cke) cke_at = cyc;
      if (init_done && !p_done) done_at = cyc;
      if (ref_req && !p_req) begin
        if (n_rise < 8) rise_at[n_rise] = cyc;
        n_rise++;
      end
      if (!ref_req && p_req) n_fall++;
      if (!sd_cke && !sd_cs_n) n_bad++;
      if (sd_cke) begin
        case (c)
          4'b0111: ;
          4'b0010: begin
            pre_at = cyc; n_pre++;
            if (!(sd_addr == 13'h0400 && sd_ba == 0)) pre_a10_ok = 1'b0;
          end
          4'b0001: begin
            if (!init_done) begin
              if (n_ref_init < 16) ref_at[n_ref_init] = cyc;
              n_ref_init++;
            end else begin
              ready_ref_at = cyc; n_ref_ready++;
            end
          end
          4'b0000: begin
            mrs_at = cyc; n_mrs++;
            if (!(sd_addr == 13'h0220 && sd_ba == 0)) mrs_ok = 1'b0;
          end
          default: n_bad++;
        endcase
      end
      p_cke = sd_cke; p_done = init_done; p_req = ref_req;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1 cke in reset", int'(sd_cke), 0);
    chk("R1 cs_n in reset", int'(sd_cs_n), 1);
    chk("R1 done/req in reset", int'(init_done) + int'(ref_req), 0);
    rst_n = 1'b1;
    repeat (6) step();
    chk("R1 idle stays deselected", int'(sd_cke) + int'(!sd_cs_n), 0);
  endtask

  task automatic t_bringup();
    int s0;
    s0 = cyc;
    pulse_start();
    chk("R2 NOP after start", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    repeat (10) step();
    pulse_start();
    for (int i = 0; i < 400 && !init_done; i++) step();
    chk("R2 cke rise cycle", cke_at, s0 + 1);
    chk("R3 precharge after settle", pre_at, cke_at + SETTLE);
    chk("R3 bit10/bank on precharge", int'(pre_a10_ok), 1);
    chk("R3 one precharge", n_pre, 1);
    chk("R4 refresh count", n_ref_init, NREF);
    chk("R4 first refresh", ref_at[0], pre_at + TRP);
    for (int k = 1; k < NREF; k++)
      chk("R4 refresh spacing", ref_at[k] - ref_at[k-1], TRC);
    chk("R5 mode load spacing", mrs_at, ref_at[NREF-1] + TRC);
    chk("R5 mode value", int'(mrs_ok), 1);
    chk("R5 one mode load", n_mrs, 1);
    chk("R6 done delay", done_at, mrs_at + TMRD);
    chk("R7 no illegal codes", n_bad, 0);
    chk("R8 no early req", n_rise, 0);
  endtask

  task automatic t_refresh();
    int g;
    while (cyc < done_at + 2*IVL + 10) step();
    chk("R8 first req rise", rise_at[0], done_at + IVL);
    chk("R9 req held, single", n_rise * 10 + n_fall, 10);
    chk("R9 req still high", int'(ref_req), 1);
    ref_grant = 1'b1; g = cyc;
    step();
    ref_grant = 1'b0;
    chk("R10 refresh after grant", ready_ref_at, g + 1);
    chk("R10 req cleared", int'(ref_req), 0);
    chk("R9 one grant clears all", n_ref_ready, 1);
    repeat (4) step();
    ref_grant = 1'b1;
    step();
    ref_grant = 1'b0;
    repeat (2) step();
    chk("R10 idle grant gives nothing", n_ref_ready, 1);
    pulse_start();
    repeat (2) step();
    chk("R2 start ignored when ready",
        int'(sd_cke) + int'(init_done) + n_pre + n_mrs, 4);
    chk("R6 done held", int'(init_done), 1);
    while (cyc < done_at + 3*IVL + 2) step();
    chk("R8 second req on grid", rise_at[1], done_at + 3*IVL);
    chk("R7 no illegal codes late", n_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ref_grant = 1'b0;
    repeat (3) step();
    t_reset();
    t_bringup();
    t_refresh();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

endmodule